// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table in memory. The virtual address is cut into three fields. The top 10 bits index the first-level table. The next 10 bits index a second-level table. The low 12 bits are the byte offset within the page. The first-level table starts at a root address held on an input. That input also has a length bound, which limits how many first-level entries exist.

A translation request is accepted only when the walker is idle, and only one translation is in flight at a time. The walker issues at most two dependent reads on a simple memory port, with one read outstanding at a time. It then returns either a physical address or a fault code. The fault code separates four cases:

- a first-level index beyond the table length;
- an empty entry;
- an entry whose page or table has been moved to backing store (its disk location is passed out);
- a write to a page marked read-only.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, `req_ready` is 1 and both `res_valid` and `mem_req` are 0.
- R2: The first read after acceptance is at `root_base + 4*vaddr[31:22]`.
- R3: When the first-level entry is usable, the second read is at `{entry[31:12], 12'h000} + 4*vaddr[21:12]`. A successful walk makes exactly two reads.
- R4: A successful walk reports `res_fault` = 0 and `res_paddr = {leaf[31:12], vaddr[11:0]}`. `res_valid` is high for exactly one cycle.
- R5: If `vaddr[31:22] >= tbl_len`, the result is fault code 1, no memory read is made, and `res_valid` rises in the cycle right after acceptance.
- R6: An entry with bit 0 = 0 and bits 31:1 all zero is empty, at either level. It gives fault code 2 and a `res_paddr` of 0. An empty first-level entry ends the walk after one read.
- R7: An entry with bit 0 = 0 and bits 31:1 nonzero is on disk, at either level. It gives fault code 3, with bits 31:1 on `res_disk` and `res_paddr` = 0. For all other outcomes `res_disk` is 0.
- R8: A write request (`req_write` = 1) whose leaf entry has bit 1 set gives fault code 4 and `res_paddr` = 0. A read of the same page succeeds. Bit 1 of a first-level entry has no effect.
- R9: From acceptance until the cycle after `res_valid`, `req_ready` is 0. `mem_req` is a one-cycle pulse per read, and it is never high together with `res_valid`.
- R10: Any read latency is tolerated. With a response L cycles after the zero-wait case on each read, the result appears 2*L cycles later than it does with zero wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 32 | Physical byte address of the first-level table |
| tbl_len | input | 11 | Number of first-level entries in use (0 to 1024) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted on this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_req | output | 1 | One-cycle pulse starting a table read |
| mem_addr | output | 32 | Byte address of the table entry to read |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Table entry read from memory |
| res_valid | output | 1 | Result valid, one cycle |
| res_fault | output | 3 | 0 ok, 1 length, 2 empty, 3 on disk, 4 write protect |
| res_paddr | output | 32 | Physical address, 0 on any fault |
| res_disk | output | 31 | Disk location for fault code 3, otherwise 0 |

## Verification
The hardest outcomes to reach are the ones that depend on what was read at the first level. Examples are a first-level entry that is on disk, or a read-only bit at the first level that must have no effect. A port-level request alone cannot reach them. The bench fills its own sparse memory model with hand-built tables, placing chosen entries at computed first-level and second-level slots. It also records every read address, so the exact address sequence and read count of each walk are checked. A per-test latency setting on the memory model stretches the wait states, so each wait state is held across many cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_OUT = 3'd1,
        ST_WT_OUT = 3'd2,
        ST_RD_IN  = 3'd3,
        ST_WT_IN  = 3'd4,
        ST_DONE   = 3'd5
    } walk_st_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_LEN     = 3'd1,
        FLT_EMPTY   = 3'd2,
        FLT_ON_DISK = 3'd3,
        FLT_PROT    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ENT_MAPPED  = 2'd0,
        ENT_EMPTY   = 2'd1,
        ENT_ON_DISK = 2'd2
    } ent_kind_e;

endpackage

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
#(
    parameter int PTE_W   = 32,
    parameter int FRAME_W = 20
) (
    input  logic [PTE_W-1:0]   entry,
    output ent_kind_e          kind,
    output logic               ro,
    output logic [FRAME_W-1:0] frame,
    output logic [PTE_W-2:0]   disk
);

    always_comb begin
        frame = entry[PTE_W-1 -: FRAME_W];
        disk  = entry[PTE_W-1:1];
        ro    = entry[1];
        if (entry[0]) begin
            kind = ENT_MAPPED;
        end else if (|entry[PTE_W-1:1]) begin
            kind = ENT_ON_DISK;
        end else begin
            kind = ENT_EMPTY;
        end
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W   = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int PTE_W  = 32
) (
    input  logic [PA_W-1:0]       root,
    input  logic [PA_W-OFF_W-1:0] tbl_frame,
    input  logic [IDX_W-1:0]      idx_outer,
    input  logic [IDX_W-1:0]      idx_inner,
    output logic [PA_W-1:0]       outer_addr,
    output logic [PA_W-1:0]       inner_addr
);

    localparam int ENT_SH = $clog2(PTE_W / 8);
    localparam int PAD_W  = PA_W - IDX_W - ENT_SH;

    logic [PA_W-1:0] outer_ofs;
    logic [PA_W-1:0] inner_ofs;

    always_comb begin
        outer_ofs  = {{PAD_W{1'b0}}, idx_outer, {ENT_SH{1'b0}}};
        inner_ofs  = {{PAD_W{1'b0}}, idx_inner, {ENT_SH{1'b0}}};
        outer_addr = root + outer_ofs;
        inner_addr = {tbl_frame, {OFF_W{1'b0}}} + inner_ofs;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   root_base,
    input  logic [IDX_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              res_valid,
    output logic [2:0]        res_fault,
    output logic [PA_W-1:0]   res_paddr,
    output logic [PTE_W-2:0]  res_disk
);

    localparam int FRAME_W = PA_W - OFF_W;
    localparam int DISK_W  = PTE_W - 1;

    typedef struct packed {
        walk_st_e            st;
        logic [VA_W-1:0]     vaddr;
        logic                wr;
        logic [PA_W-1:0]     root;
        logic [FRAME_W-1:0]  tframe;
        logic [PA_W-1:0]     paddr;
        fault_e              fault;
        logic [DISK_W-1:0]   disk;
    } walk_t;

    walk_t q, d;

    ent_kind_e          dec_kind;
    logic               dec_ro;
    logic [FRAME_W-1:0] dec_frame;
    logic [DISK_W-1:0]  dec_disk;
    logic [PA_W-1:0]    outer_addr;
    logic [PA_W-1:0]    inner_addr;
    logic [IDX_W-1:0]   new_outer_idx;

    ptw_entry_dec #(
        .PTE_W   (PTE_W),
        .FRAME_W (FRAME_W)
    ) dec_i (
        .entry (mem_rdata),
        .kind  (dec_kind),
        .ro    (dec_ro),
        .frame (dec_frame),
        .disk  (dec_disk)
    );

    ptw_addr_gen #(
        .PA_W  (PA_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W),
        .PTE_W (PTE_W)
    ) agen_i (
        .root       (q.root),
        .tbl_frame  (q.tframe),
        .idx_outer  (q.vaddr[VA_W-1 -: IDX_W]),
        .idx_inner  (q.vaddr[OFF_W +: IDX_W]),
        .outer_addr (outer_addr),
        .inner_addr (inner_addr)
    );

    assign new_outer_idx = req_vaddr[VA_W-1 -: IDX_W];

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.vaddr  = req_vaddr;
                    d.wr     = req_write;
                    d.root   = root_base;
                    d.tframe = '0;
                    d.paddr  = '0;
                    d.disk   = '0;
                    if ({1'b0, new_outer_idx} >= tbl_len) begin
                        d.fault = FLT_LEN;
                        d.st    = ST_DONE;
                    end else begin
                        d.fault = FLT_NONE;
                        d.st    = ST_RD_OUT;
                    end
                end
            end
            ST_RD_OUT: d.st = ST_WT_OUT;
            ST_WT_OUT: begin
                if (mem_rvalid) begin
                    unique case (dec_kind)
                        ENT_MAPPED: begin
                            d.tframe = dec_frame;
                            d.st     = ST_RD_IN;
                        end
                        ENT_ON_DISK: begin
                            d.fault = FLT_ON_DISK;
                            d.disk  = dec_disk;
                            d.st    = ST_DONE;
                        end
                        default: begin
                            d.fault = FLT_EMPTY;
                            d.st    = ST_DONE;
                        end
                    endcase
                end
            end
            ST_RD_IN: d.st = ST_WT_IN;
            ST_WT_IN: begin
                if (mem_rvalid) begin
                    d.st = ST_DONE;
                    unique case (dec_kind)
                        ENT_MAPPED: begin
                            if (q.wr && dec_ro) begin
                                d.fault = FLT_PROT;
                            end else begin
                                d.paddr = {dec_frame, q.vaddr[OFF_W-1:0]};
                            end
                        end
                        ENT_ON_DISK: begin
                            d.fault = FLT_ON_DISK;
                            d.disk  = dec_disk;
                        end
                        default: d.fault = FLT_EMPTY;
                    endcase
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign mem_req   = (q.st == ST_RD_OUT) || (q.st == ST_RD_IN);
    assign mem_addr  = (q.st == ST_RD_IN) ? inner_addr : outer_addr;
    assign res_valid = (q.st == ST_DONE);
    assign res_fault = q.fault;
    assign res_paddr = q.paddr;
    assign res_disk  = q.disk;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int DISK_W = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W:0]    tbl_len,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              mem_req,
    input logic              res_valid,
    input logic [2:0]        res_fault,
    input logic [PA_W-1:0]   res_paddr,
    input logic [DISK_W-1:0] res_disk
);

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (req_ready && !res_valid && !mem_req);
        end
    end

    // R5
    len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1 -: IDX_W]} >= tbl_len))
        |=> (res_valid && res_fault == 3'd1 && !mem_req));

    // R4
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || res_valid) |-> !req_ready);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_req);

    // R6
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 3'd0) |-> (res_paddr == '0));

    // R7
    disk_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_fault == 3'd3) ? (res_disk != '0) : (res_disk == '0)));

endmodule

bind pt_walker ptw_checker #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .IDX_W  (IDX_W),
    .DISK_W (PTE_W - 1)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_len   (tbl_len),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .mem_req   (mem_req),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_paddr (res_paddr),
    .res_disk  (res_disk)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

    localparam logic [31:0] ROOT = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = ROOT;
    logic [10:0] tbl_len = 11'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic [2:0]  res_fault;
    logic [31:0] res_paddr;
    logic [30:0] res_disk;

    int vecs = 0;
    int miss = 0;

    pt_walker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .root_base  (root_base),
        .tbl_len    (tbl_len),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .res_valid  (res_valid),
        .res_fault  (res_fault),
        .res_paddr  (res_paddr),
        .res_disk   (res_disk)
    );

    always #4 clk = ~clk;

    // behavioural memory: sparse, one read pending, programmable latency
    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          lat_cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [256];

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            rd_log[rd_cnt[7:0]] <= mem_addr;
            rd_cnt    <= rd_cnt + 1;
            pend      <= 1'b1;
            pend_addr <= mem_addr;
            lat_cnt   <= lat;
        end else if (pend) begin
            if (lat_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
                pend       <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    // results of the last walk
    logic [2:0]  g_flt;
    logic [31:0] g_pa;
    logic [30:0] g_dk;
    int          g_nrd;
    int          g_cyc;
    int          g_start;
    bit          g_busy_ok;
    bit          g_pulse_ok;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] va(input int o, input int i, input int off);
        return {o[9:0], i[9:0], off[11:0]};
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] e);
        mem[a] = e;
    endtask

    task automatic walk(input logic [31:0] v, input bit wr);
        g_start   = rd_cnt;
        g_busy_ok = 1'b1;
        @(negedge clk);
        req_vaddr = v;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g_cyc = 1;
        while (!res_valid && g_cyc < 300) begin
            if (req_ready) g_busy_ok = 1'b0;
            @(negedge clk);
            g_cyc++;
        end
        if (req_ready) g_busy_ok = 1'b0;
        g_flt = res_fault;
        g_pa  = res_paddr;
        g_dk  = res_disk;
        @(negedge clk);
        g_pulse_ok = !res_valid && req_ready;
        g_nrd = rd_cnt - g_start;
    endtask

    task automatic t_reset;
        chk("R1", "req_ready in reset", {31'h0, req_ready}, 32'h1);
        chk("R1", "res_valid in reset", {31'h0, res_valid}, 32'h0);
        chk("R1", "mem_req in reset", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_basic;
        put(ROOT + 32'd12, 32'h0020_1001);
        put(32'h0020_1014, 32'h0055_5001);
        walk(va(3, 5, 12'hABC), 1'b0);
        chk("R4", "basic fault", {29'h0, g_flt}, 32'h0);
        chk("R4", "basic paddr", g_pa, 32'h0055_5ABC);
        chk("R3", "basic read count", g_nrd, 32'd2);
        chk("R2", "basic outer addr", rd_log[g_start[7:0]], ROOT + 32'd12);
        chk("R3", "basic inner addr", rd_log[8'(g_start + 1)], 32'h0020_1014);
        chk("R10", "zero-wait result cycle", g_cyc, 32'd7);
        chk("R9", "busy while walking", {31'h0, g_busy_ok}, 32'h1);
        chk("R4", "one-cycle result", {31'h0, g_pulse_ok}, 32'h1);
    endtask

    task automatic t_top_corner;
        tbl_len = 11'd1024;
        // outer entry with its read-only bit set: must not matter (R8)
        put(ROOT + 32'h0000_0FFC, 32'h0030_0003);
        put(32'h0030_0FFC, 32'hFFFF_F001);
        walk(va(1023, 1023, 12'hFFF), 1'b1);
        chk("R8", "outer ro ignored fault", {29'h0, g_flt}, 32'h0);
        chk("R4", "max index paddr", g_pa, 32'hFFFF_FFFF);
        chk("R2", "max outer addr", rd_log[g_start[7:0]], 32'h0010_0FFC);
        chk("R3", "max inner addr", rd_log[8'(g_start + 1)], 32'h0030_0FFC);
        tbl_len = 11'd16;
    endtask

    task automatic t_length;
        walk(va(16, 0, 0), 1'b0);
        chk("R5", "idx==len fault", {29'h0, g_flt}, 32'h1);
        chk("R5", "idx==len reads", g_nrd, 32'd0);
        chk("R5", "idx==len result cycle", g_cyc, 32'd1);
        chk("R5", "idx==len paddr", g_pa, 32'h0);
        put(ROOT + 32'd60, 32'h0021_0001);
        put(32'h0021_0008, 32'h0012_3001);
        walk(va(15, 2, 12'h010), 1'b0);
        chk("R5", "idx==len-1 fault", {29'h0, g_flt}, 32'h0);
        chk("R5", "idx==len-1 paddr", g_pa, 32'h0012_3010);
        tbl_len = 11'd0;
        walk(va(0, 0, 0), 1'b0);
        chk("R5", "len 0 fault", {29'h0, g_flt}, 32'h1);
        chk("R5", "len 0 reads", g_nrd, 32'd0);
        tbl_len = 11'd16;
    endtask

    task automatic t_empty;
        put(ROOT + 32'd28, 32'h0);
        walk(va(7, 1, 0), 1'b0);
        chk("R6", "outer empty fault", {29'h0, g_flt}, 32'h2);
        chk("R6", "outer empty reads", g_nrd, 32'd1);
        chk("R6", "outer empty paddr", g_pa, 32'h0);
        put(ROOT + 32'd32, 32'h0040_0001);
        put(32'h0040_0008, 32'h0);
        walk(va(8, 2, 12'h444), 1'b0);
        chk("R6", "inner empty fault", {29'h0, g_flt}, 32'h2);
        chk("R6", "inner empty reads", g_nrd, 32'd2);
        chk("R6", "inner empty paddr", g_pa, 32'h0);
    endtask

    task automatic t_disk;
        put(ROOT + 32'd36, 32'h0041_0001);
        put(32'h0041_0010, {31'h1234567, 1'b0});
        walk(va(9, 4, 12'h321), 1'b0);
        chk("R7", "inner on disk fault", {29'h0, g_flt}, 32'h3);
        chk("R7", "inner disk location", {1'b0, g_dk}, 32'h0123_4567);
        chk("R7", "inner on disk paddr", g_pa, 32'h0);
        put(ROOT + 32'd40, {31'h7654321, 1'b0});
        walk(va(10, 4, 0), 1'b0);
        chk("R7", "outer on disk fault", {29'h0, g_flt}, 32'h3);
        chk("R7", "outer disk location", {1'b0, g_dk}, 32'h0765_4321);
        chk("R7", "outer on disk reads", g_nrd, 32'd1);
    endtask

    task automatic t_protect;
        put(ROOT + 32'd44, 32'h0050_0001);
        put(32'h0050_0018, 32'h0066_6003);
        put(32'h0050_001C, 32'h0077_7001);
        walk(va(11, 6, 12'h0F0), 1'b1);
        chk("R8", "write ro fault", {29'h0, g_flt}, 32'h4);
        chk("R8", "write ro paddr", g_pa, 32'h0);
        chk("R7", "no disk on protect", {1'b0, g_dk}, 32'h0);
        walk(va(11, 6, 12'h0F0), 1'b0);
        chk("R8", "read ro fault", {29'h0, g_flt}, 32'h0);
        chk("R8", "read ro paddr", g_pa, 32'h0066_60F0);
        walk(va(11, 7, 12'h00C), 1'b1);
        chk("R8", "write rw fault", {29'h0, g_flt}, 32'h0);
        chk("R8", "write rw paddr", g_pa, 32'h0077_700C);
    endtask

    task automatic t_latency;
        lat = 6;
        walk(va(3, 5, 12'h123), 1'b0);
        chk("R10", "slow memory paddr", g_pa, 32'h0055_5123);
        chk("R10", "slow memory result cycle", g_cyc, 32'd19);
        chk("R9", "busy while slow", {31'h0, g_busy_ok}, 32'h1);
        chk("R3", "slow memory reads", g_nrd, 32'd2);
        lat = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_top_corner();
        t_length();
        t_empty();
        t_disk();
        t_protect();
        t_latency();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule